// File: doc/BRIEF.md
# Serial Register-Port Slave

This block connects a two-wire serial bus (I2C) to a small register file of nine 8-bit locations. It oversamples the clock and data lines with the system clock, cleans them through a synchronizer and a glitch filter, and recognises START, repeated START and STOP conditions. After a START it takes a header byte. The header carries a fixed four-bit prefix, three bits that must match the strap inputs, and a read/write flag. A register address byte follows the header. The slave then runs write bursts or read bursts through a pointer that steps by one after every data byte.

On the register side the block drives a pointer-valued address, write data and a one-cycle write strobe. It reads data back on a separate input and pulses a flag when a STOP is seen. The data line is open drain: the block only produces an enable that pulls the line low. To read, the host sends a write header with the address, then a repeated START and a read header. Bytes follow for as long as the host acknowledges them.

Top module: `i2c_reg_slave`

## Requirements
- R1: While reset is high, and in the first cycle after reset, sda_oe, reg_we and stop_pulse are all 0.
- R2: A header byte whose upper seven bits equal binary 1010 followed by strap[2:0] is acknowledged, meaning sda_oe pulls the ninth bit low. Any other header gets no acknowledge, and the bytes after it in that transfer are neither acknowledged nor written.
- R3: In a write, the pointer loads from the address byte. Every data byte is acknowledged and presented once on reg_wdata with a single-cycle reg_we at reg_addr equal to the pointer. The pointer then moves up by one.
- R4: When the pointer is at location 8 and steps, it returns to location 0, in write bursts and in read bursts alike.
- R5: A read is a write header, an address byte, a repeated START and a header with the LSB set to 1. The slave then sends the byte at the pointer, MSB first.
- R6: The slave keeps sending successive bytes while the host drives the ninth bit low. After a host NACK it releases SDA and sends nothing more.
- R7: Each STOP gives exactly one one-cycle stop_pulse and returns the slave to idle. Bus activity after it, without a START, is neither acknowledged nor written.
- R8: A low pulse on SDA shorter than the filter length, while SCL is high, is seen as neither START nor STOP. The transfer in progress completes unchanged.
- R9: A START part-way through a byte discards that byte and starts header reception again.
- R10: An address byte above 8 is acknowledged and sets the pointer to 0.
- R11: sda_oe changes only while the SCL input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap | input | 3 | Header match bits |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | 4 | Current pointer, used as the register address |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents at reg_addr |
| stop_pulse | output | 1 | One-cycle pulse per STOP |

## Verification
Every line change reaches the state machine about seven system cycles after it happens on the pins: two synchronizer stages, four filter samples and one registered state update. sda_oe and reg_we therefore change about seven cycles after an SCL falling edge, and the bench leaves a quarter bit of sixteen cycles before it drives the next value. The bench samples the slave's SDA drive in the middle of the SCL high phase, long after that delay. Write strobes and stop pulses are counted by monitors, and those counts are compared after the STOP has settled. So no check depends on the exact arrival cycle.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int DATA_W   = 8;
  localparam int STRAP_W  = 3;
  localparam int PREFIX_W = DATA_W - 1 - STRAP_W;
  localparam logic [PREFIX_W-1:0] ID_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } slv_state_e;

  typedef enum logic [1:0] {
    BK_ID,
    BK_ADDR,
    BK_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2cr_line_filter.sv
module i2cr_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int FCW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FCW-1:0]         run_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end

  // output follows the synced level only after FILT_LEN differing samples
  always_ff @(posedge clk) begin
    if (rst) begin
      dout  <= 1'b1;
      run_q <= '0;
    end else if (synced == dout) begin
      run_q <= '0;
    end else if (run_q == FCW'(FILT_LEN - 1)) begin
      dout  <= synced;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2cr_bus_events.sv
module i2cr_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt,
  output logic sda_lvl
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
  assign sda_lvl   = sda_f;
endmodule

// File: rtl/i2cr_xfer_fsm.sv
module i2cr_xfer_fsm
  import i2cr_pkg::*;
#(
  parameter int NUM_REGS = 9,
  parameter int AW       = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_evt,
  input  logic               stop_evt,
  input  logic               sda_lvl,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DATA_W-1:0]  rdata,
  output logic               sda_oe,
  output logic [AW-1:0]      ptr,
  output logic [DATA_W-1:0]  wdata,
  output logic               we,
  output logic               stop_pulse
);
  localparam int LAST = NUM_REGS - 1;
  localparam int CW   = $clog2(DATA_W + 1);

  slv_state_e          state;
  byte_kind_e          kind;
  logic [CW-1:0]       cnt;
  logic [DATA_W-1:0]   rx_sh, tx_sh;
  logic                byte_done, rd_mode, mack;
  logic [AW-1:0]       ptr_nxt;

  assign ptr_nxt = (ptr == AW'(LAST)) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      kind       <= BK_ID;
      cnt        <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      byte_done  <= 1'b0;
      rd_mode    <= 1'b0;
      mack       <= 1'b0;
      ptr        <= '0;
      wdata      <= '0;
      we         <= 1'b0;
      sda_oe     <= 1'b0;
      stop_pulse <= 1'b0;
    end else begin
      we         <= 1'b0;
      stop_pulse <= 1'b0;
      if (stop_evt) begin
        state      <= ST_IDLE;
        sda_oe     <= 1'b0;
        stop_pulse <= 1'b1;
      end else if (start_evt) begin
        state     <= ST_RX;
        kind      <= BK_ID;
        cnt       <= '0;
        byte_done <= 1'b0;
        sda_oe    <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              rx_sh     <= {rx_sh[DATA_W-2:0], sda_lvl};
              cnt       <= cnt + 1'b1;
              byte_done <= (cnt == CW'(DATA_W - 1));
            end else if (scl_fall && byte_done) begin
              byte_done <= 1'b0;
              cnt       <= '0;
              case (kind)
                BK_ID: begin
                  if (rx_sh[DATA_W-1:1] == {ID_PREFIX, strap}) begin
                    sda_oe  <= 1'b1;
                    rd_mode <= rx_sh[0];
                    state   <= ST_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                BK_ADDR: begin
                  ptr     <= (rx_sh > DATA_W'(LAST)) ? '0 : rx_sh[AW-1:0];
                  sda_oe  <= 1'b1;
                  rd_mode <= 1'b0;
                  state   <= ST_ACK;
                end
                default: begin
                  wdata   <= rx_sh;
                  we      <= 1'b1;
                  sda_oe  <= 1'b1;
                  rd_mode <= 1'b0;
                  state   <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              if (kind == BK_ID && rd_mode) begin
                tx_sh  <= rdata;
                sda_oe <= ~rdata[DATA_W-1];
                cnt    <= '0;
                state  <= ST_TX;
              end else if (kind == BK_ID) begin
                kind  <= BK_ADDR;
                state <= ST_RX;
              end else if (kind == BK_ADDR) begin
                kind  <= BK_DATA;
                state <= ST_RX;
              end else begin
                ptr   <= ptr_nxt;
                state <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == CW'(DATA_W - 1)) begin
                sda_oe <= 1'b0;
                ptr    <= ptr_nxt;
                cnt    <= '0;
                state  <= ST_MACK;
              end else begin
                tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                sda_oe <= ~tx_sh[DATA_W-2];
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                tx_sh  <= rdata;
                sda_oe <= ~rdata[DATA_W-1];
                cnt    <= '0;
                state  <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2cr_pkg::*;
#(
  parameter int NUM_REGS    = 9,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  localparam int AW         = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap,
  output logic               sda_oe,
  output logic [AW-1:0]      reg_addr,
  output logic [DATA_W-1:0]  reg_wdata,
  output logic               reg_we,
  input  logic [DATA_W-1:0]  reg_rdata,
  output logic               stop_pulse
);
  logic [1:0] raw_bus, filt_bus;
  logic scl_rise, scl_fall, start_evt, stop_evt, sda_lvl;

  assign raw_bus = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2cr_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_bus[g]),
      .dout(filt_bus[g])
    );
  end

  i2cr_bus_events u_events (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (filt_bus[1]),
    .sda_f    (filt_bus[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .sda_lvl  (sda_lvl)
  );

  i2cr_xfer_fsm #(
    .NUM_REGS(NUM_REGS),
    .AW      (AW)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_lvl   (sda_lvl),
    .strap     (strap),
    .rdata     (reg_rdata),
    .sda_oe    (sda_oe),
    .ptr       (reg_addr),
    .wdata     (reg_wdata),
    .we        (reg_we),
    .stop_pulse(stop_pulse)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int NUM_REGS = 9,
  parameter int AW       = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          stop_pulse
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!sda_oe && !reg_we && !stop_pulse));

  assert_we_single_R3: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  assert_we_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !scl_i);

  assert_addr_range_R4: assert property (@(posedge clk) disable iff (rst)
    reg_addr <= AW'(NUM_REGS - 1));

  assert_stop_single_R7: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |=> !stop_pulse);

  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.NUM_REGS(NUM_REGS), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .stop_pulse(stop_pulse)
);

// File: tb/test_i2c_reg_slave.sv
`timescale 1ns/1ps
module test_i2c_reg_slave;
  localparam int Q = 16;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe, reg_we, stop_pulse;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic sda_line;

  logic [7:0] regs [9];
  logic [7:0] expv [9];
  int wr_cnt = 0, stop_cnt = 0, oe_bad = 0;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign sda_line  = m_sda & ~sda_oe;
  assign reg_rdata = (reg_addr < 4'd9) ? regs[reg_addr] : 8'h00;

  i2c_reg_slave i_i2c_reg_slave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .strap(STRAP),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .stop_pulse(stop_pulse)
  );

  always @(posedge clk) begin
    if (!rst && reg_we && reg_addr < 4'd9) regs[reg_addr] <= reg_wdata;
    if (!rst && reg_we) wr_cnt <= wr_cnt + 1;
    if (!rst && stop_pulse) stop_cnt <= stop_cnt + 1;
  end

  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && sda_oe != oe_prev && m_scl) oe_bad++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; waitq(Q);
    m_scl = 1'b1; waitq(Q);
    m_sda = 1'b0; waitq(Q);
    m_scl = 1'b0; waitq(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; waitq(Q);
    m_scl = 1'b1; waitq(Q);
    m_sda = 1'b1; waitq(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; waitq(Q);
      m_scl = 1'b1;
      if (glitch && i == 3) begin
        waitq(4); m_sda = 1'b0; waitq(2); m_sda = 1'b1; waitq(2 * Q - 6);
      end else begin
        waitq(2 * Q);
      end
      m_scl = 1'b0; waitq(Q);
    end
    m_sda = 1'b1; waitq(Q);
    m_scl = 1'b1; waitq(Q);
    acked = !sda_line;
    waitq(Q);
    m_scl = 1'b0; waitq(Q);
  endtask

  task automatic recv_byte(input bit host_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitq(Q);
      m_scl = 1'b1; waitq(Q);
      b[i] = sda_line;
      waitq(Q);
      m_scl = 1'b0; waitq(Q);
    end
    m_sda = !host_ack; waitq(Q);
    m_scl = 1'b1; waitq(2 * Q);
    m_scl = 1'b0; waitq(Q);
  endtask

  function automatic logic [7:0] hdr(input bit rd);
    return {4'b1010, STRAP, rd};
  endfunction

  task automatic cmp_regs(input string tag);
    for (int k = 0; k < 9; k++)
      chk(regs[k] == expv[k], tag, regs[k], expv[k]);
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
    chk(reg_we == 1'b0, "R1 reg_we", reg_we, 0);
    chk(stop_pulse == 1'b0, "R1 stop_pulse", stop_pulse, 0);
  endtask

  task automatic t_write_burst();
    bit a; int w0, s0;
    w0 = wr_cnt; s0 = stop_cnt;
    bus_start();
    send_byte(hdr(0), 0, a); chk(a, "R2 header ack", a, 1);
    send_byte(8'h01, 0, a);  chk(a, "R3 addr ack", a, 1);
    send_byte(8'hA5, 0, a);  chk(a, "R3 data ack", a, 1);
    send_byte(8'h3C, 0, a);  chk(a, "R3 data ack", a, 1);
    send_byte(8'hF0, 0, a);  chk(a, "R3 data ack", a, 1);
    bus_stop();
    expv[1] = 8'hA5; expv[2] = 8'h3C; expv[3] = 8'hF0;
    cmp_regs("R3 contents");
    chk(wr_cnt - w0 == 3, "R3 strobe count", wr_cnt - w0, 3);
    chk(stop_cnt - s0 == 1, "R7 stop pulses", stop_cnt - s0, 1);
  endtask

  task automatic t_wrap_write();
    bit a;
    bus_start();
    send_byte(hdr(0), 0, a);
    send_byte(8'h07, 0, a);
    send_byte(8'h11, 0, a);
    send_byte(8'h22, 0, a);
    send_byte(8'h33, 0, a);
    bus_stop();
    expv[7] = 8'h11; expv[8] = 8'h22; expv[0] = 8'h33;
    cmp_regs("R4 write wrap");
  endtask

  task automatic t_read(input logic [7:0] addr, input int n);
    bit a; logic [7:0] d; int p;
    bus_start();
    send_byte(hdr(0), 0, a);
    send_byte(addr, 0, a);
    bus_start();
    send_byte(hdr(1), 0, a); chk(a, "R5 read header ack", a, 1);
    p = (addr > 8) ? 0 : addr;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      chk(d == expv[p], "R5 read data", d, expv[p]);
      p = (p == 8) ? 0 : p + 1;
    end
    chk(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_mismatch();
    bit a; int w0;
    w0 = wr_cnt;
    bus_start();
    send_byte({4'b1010, 3'b100, 1'b0}, 0, a); chk(!a, "R2 wrong strap nack", a, 0);
    send_byte(8'h04, 0, a); chk(!a, "R2 addr ignored", a, 0);
    send_byte(8'h99, 0, a); chk(!a, "R2 data ignored", a, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b0}, 0, a); chk(!a, "R2 wrong prefix nack", a, 0);
    bus_stop();
    chk(wr_cnt == w0, "R2 no writes", wr_cnt - w0, 0);
  endtask

  task automatic t_no_start();
    bit a; int w0;
    w0 = wr_cnt;
    send_byte(hdr(0), 0, a); chk(!a, "R7 idle header ignored", a, 0);
    send_byte(8'h05, 0, a);
    send_byte(8'hEE, 0, a);
    chk(wr_cnt == w0, "R7 idle no write", wr_cnt - w0, 0);
    bus_stop();
  endtask

  task automatic t_glitch();
    bit a; int s0;
    s0 = stop_cnt;
    bus_start();
    send_byte(hdr(0), 0, a);
    send_byte(8'h04, 0, a);
    send_byte(8'h5A, 1, a); chk(a, "R8 glitched byte ack", a, 1);
    send_byte(8'h6B, 0, a);
    chk(stop_cnt == s0, "R8 no false stop", stop_cnt - s0, 0);
    bus_stop();
    expv[4] = 8'h5A; expv[5] = 8'h6B;
    cmp_regs("R8 contents");
  endtask

  task automatic t_abort();
    bit a; int w0;
    w0 = wr_cnt;
    bus_start();
    send_byte(hdr(0), 0, a);
    send_byte(8'h02, 0, a);
    for (int i = 0; i < 4; i++) begin
      m_sda = 1'b0; waitq(Q); m_scl = 1'b1; waitq(2 * Q); m_scl = 1'b0; waitq(Q);
    end
    bus_start();
    send_byte(hdr(0), 0, a); chk(a, "R9 header after abort", a, 1);
    send_byte(8'h06, 0, a);
    send_byte(8'h77, 0, a);
    bus_stop();
    expv[6] = 8'h77;
    chk(wr_cnt - w0 == 1, "R9 one write", wr_cnt - w0, 1);
    cmp_regs("R9 contents");
  endtask

  task automatic t_addr_high();
    bit a;
    bus_start();
    send_byte(hdr(0), 0, a);
    send_byte(8'h0C, 0, a); chk(a, "R10 high addr ack", a, 1);
    send_byte(8'h42, 0, a);
    bus_stop();
    expv[0] = 8'h42;
    cmp_regs("R10 contents");
  endtask

  initial begin
    for (int k = 0; k < 9; k++) begin
      regs[k] = 8'h00;
      expv[k] = 8'h00;
    end
    repeat (5) @(negedge clk);
    t_reset();
    rst = 1'b0;
    waitq(4 * Q);
    t_write_burst();
    t_wrap_write();
    t_read(8'h01, 3);
    t_read(8'h08, 3);
    t_mismatch();
    t_no_start();
    t_glitch();
    t_abort();
    t_addr_high();
    t_read(8'h00, 2);
    chk(oe_bad == 0, "R11 sda_oe change with scl high", oe_bad, 0);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule